// File: doc/BRIEF.md
# Video Memory DMA Engine

This block fills the private memories of a video processor without help from the CPU. Once the control-port decoder has taken in a complete two-word command, it pulses a start strobe along with the command code and destination address. If DMA is enabled and the command asks for it, the engine runs one of three operations. The choice comes from the two top bits of the high source register.

The first operation copies 16-bit words from system memory into VRAM, colour memory or scroll memory. It reads them through a bus-master port after the CPU has granted the bus. The second fills a VRAM region with a single byte. The third copies bytes from one VRAM region to another.

After each element, the destination advances by the programmed auto-increment. A busy flag stays high for the whole operation, for use in the status word.

Top module: `vdma_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `bus_req` and `bus_rd` are low, and no memory write strobe is asserted.
- R2: An operation starts at the clock edge where `cmd_go` is high, `cmd_code[5]` is 1 and `dma_en` is 1. If `cmd_go` arrives with either of those bits low, it has no effect: `busy` stays low and nothing is written.
- R3: The operation is chosen by `src_hi[7:6]` at start. 0x selects a memory transfer, 10 selects a VRAM fill and 11 selects a VRAM copy.
- R4: The element count is `{len_hi,len_lo}`. It counts words for a memory transfer and bytes for fill and copy. A count of zero means 65536 elements.
- R5: A memory transfer holds `bus_req` high and reads nothing until `bus_ack` is high. Each cycle with `bus_ack` high reads one word with `bus_rd`. The first address is `{src_hi[6:0],src_mid,src_lo,1'b0}`, and each later read is 2 above the previous one. Dropping `bus_ack` pauses the transfer.
- R6: For a memory transfer, `cmd_code[3:0]` picks the target memory: 0011 selects colour memory, 0101 selects scroll memory, and every other value selects VRAM. Each element is one word write (`mem_byte`=0). The even byte gets `mem_wdata[15:8]`. The address wraps at the target's size, which is 128 bytes by default for colour and scroll memory.
- R7: The destination starts at `cmd_dest`. After every element it advances by `auto_inc`, modulo 65536, before any size wrap.
- R8: A fill writes nothing until the next `data_wr`. The fill value is `data_word[15:8]`. After that, one VRAM byte write (`mem_byte`=1, value in `mem_wdata[7:0]`) follows per cycle.
- R9: A copy reads the VRAM byte at `{src_mid,src_lo}` and writes it to the destination as a byte write. The source advances by 1 for each byte.
- R10: `busy` is high from the cycle after the start edge until the last element has been written, and then falls. `bus_req` is low again after the last word of a memory transfer.
- R11: A `cmd_go` that arrives while `busy` is high is ignored. The running operation goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Strobe: command pair accepted |
| cmd_code | input | 6 | Command code; bit 5 requests DMA, bits 3:0 select the target |
| cmd_dest | input | 16 | Destination byte address |
| dma_en | input | 1 | DMA enable bit from the mode register |
| len_lo | input | 8 | Length, low byte |
| len_hi | input | 8 | Length, high byte |
| src_lo | input | 8 | Source register, low |
| src_mid | input | 8 | Source register, middle |
| src_hi | input | 8 | Source register, high; bits 7:6 select the operation |
| auto_inc | input | 8 | Destination step per element |
| data_wr | input | 1 | Data-port write strobe |
| data_word | input | 16 | Data-port write value |
| bus_req | output | 1 | Bus request to the CPU |
| bus_ack | input | 1 | Bus grant from the CPU |
| bus_rd | output | 1 | System-bus word read this cycle |
| bus_addr | output | 24 | System-bus byte address |
| bus_rdata | input | 16 | System-bus read data, valid in the same cycle |
| vram_raddr | output | 16 | VRAM read address (data one cycle later) |
| vram_rdata | input | 8 | VRAM read byte |
| vram_we | output | 1 | VRAM write strobe |
| cram_we | output | 1 | Colour memory write strobe |
| vsram_we | output | 1 | Scroll memory write strobe |
| mem_byte | output | 1 | 1: byte write, 0: word write |
| mem_addr | output | 16 | Write byte address, wrapped to the target size |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Operation in progress |

## Verification
Two events can meet in the same cycle. A fresh start strobe can arrive while the engine is busy, and a data-port write can arrive while a fill is waiting. The bench arms a fill and pulses `cmd_go` for a memory transfer during the wait. It then sends the data word and checks two things: every write that follows is a VRAM byte write carrying the fill value, and `bus_req` never rises. A separate test holds `bus_ack` low. It confirms that `bus_req` stays up while no read or write appears, and then that the transfer resumes and finishes with the exact element count once the grant arrives.

// File: rtl/vdma_engine.sv
module vdma_engine #(
  parameter int CRAM_AW  = 7,
  parameter int VSRAM_AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_go,
  input  logic [5:0]  cmd_code,
  input  logic [15:0] cmd_dest,
  input  logic        dma_en,
  input  logic [7:0]  len_lo,
  input  logic [7:0]  len_hi,
  input  logic [7:0]  src_lo,
  input  logic [7:0]  src_mid,
  input  logic [7:0]  src_hi,
  input  logic [7:0]  auto_inc,
  input  logic        data_wr,
  input  logic [15:0] data_word,
  output logic        bus_req,
  input  logic        bus_ack,
  output logic        bus_rd,
  output logic [23:0] bus_addr,
  input  logic [15:0] bus_rdata,
  output logic [15:0] vram_raddr,
  input  logic [7:0]  vram_rdata,
  output logic        vram_we,
  output logic        cram_we,
  output logic        vsram_we,
  output logic        mem_byte,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        busy
);
  localparam logic [15:0] CRAM_MASK  = 16'((1 << CRAM_AW) - 1);
  localparam logic [15:0] VSRAM_MASK = 16'((1 << VSRAM_AW) - 1);

  typedef enum logic [2:0] {S_IDLE, S_MEM, S_FWAIT, S_FILL, S_CRD, S_CWR} st_t;
  typedef enum logic [1:0] {T_VRAM, T_CRAM, T_VSRAM} tgt_t;

  st_t         st;
  tgt_t        tgt;
  logic [16:0] cnt;
  logic [15:0] dst;
  logic [22:0] src;
  logic [7:0]  inc;
  logic [7:0]  fillb;

  wire go     = cmd_go && dma_en && cmd_code[5] && (st == S_IDLE);
  wire step   = ((st == S_MEM) && bus_ack) || (st == S_FILL) || (st == S_CWR);
  wire last   = (cnt == 17'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tgt <= T_VRAM; cnt <= '0; dst <= '0;
      src <= '0; inc <= '0; fillb <= '0;
    end else begin
      if (go) begin
        cnt <= ({len_hi, len_lo} == 16'd0) ? 17'h10000 : {1'b0, len_hi, len_lo};
        dst <= cmd_dest;
        inc <= auto_inc;
        case (cmd_code[3:0])
          4'b0011: tgt <= T_CRAM;
          4'b0101: tgt <= T_VSRAM;
          default: tgt <= T_VRAM;
        endcase
        if (!src_hi[7]) begin
          src <= {src_hi[6:0], src_mid, src_lo};
          st  <= S_MEM;
        end else begin
          src <= {7'd0, src_mid, src_lo};
          st  <= src_hi[6] ? S_CRD : S_FWAIT;
        end
      end
      if (st == S_FWAIT && data_wr) begin
        fillb <= data_word[15:8];
        st    <= S_FILL;
      end
      if (st == S_CRD) st <= S_CWR;
      if (step) begin
        dst <= dst + {8'd0, inc};
        cnt <= cnt - 17'd1;
        if (st == S_MEM) src <= src + 23'd1;
        if (st == S_CWR) begin
          src <= {7'd0, src[15:0] + 16'd1};
          st  <= last ? S_IDLE : S_CRD;
        end
        if (last) st <= S_IDLE;
      end
    end
  end

  assign busy       = (st != S_IDLE);
  assign bus_req    = (st == S_MEM);
  assign bus_rd     = (st == S_MEM) && bus_ack;
  assign bus_addr   = {src, 1'b0};
  assign vram_raddr = src[15:0];
  assign mem_byte   = (st == S_FILL) || (st == S_CWR);
  assign vram_we    = (bus_rd && tgt == T_VRAM) || mem_byte;
  assign cram_we    = bus_rd && tgt == T_CRAM;
  assign vsram_we   = bus_rd && tgt == T_VSRAM;
  assign mem_addr   = !bus_req ? dst :
                      (tgt == T_CRAM)  ? (dst & CRAM_MASK) :
                      (tgt == T_VSRAM) ? (dst & VSRAM_MASK) : dst;
  assign mem_wdata  = (st == S_MEM) ? bus_rdata :
                      {8'd0, (st == S_FILL) ? fillb : vram_rdata};

  // R5
  rd_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_req && bus_ack));
  // R5
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd)) |-> (bus_addr == $past(bus_addr) + 24'd2));
  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we, cram_we, vsram_we}));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(vram_we || cram_we || vsram_we || bus_req));
  // R7
  fill_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_FILL) && $past(st == S_FILL)) |-> (mem_addr == $past(mem_addr) + {8'd0, inc}));
endmodule

// File: tb/sim_vdma_engine.sv
module sim_vdma_engine;
  logic clk = 0, rst_n = 0;
  logic cmd_go = 0, dma_en = 1, data_wr = 0, bus_ack = 1;
  logic [5:0]  cmd_code = 0;
  logic [15:0] cmd_dest = 0, data_word = 0;
  logic [7:0]  len_lo = 0, len_hi = 0, src_lo = 0, src_mid = 0, src_hi = 0, auto_inc = 0;
  logic        bus_req, bus_rd, vram_we, cram_we, vsram_we, mem_byte, busy;
  logic [23:0] bus_addr;
  logic [15:0] bus_rdata, vram_raddr, mem_addr, mem_wdata;
  logic [7:0]  vram_rdata = 0;

  always #5 clk = ~clk;

  vdma_engine u0 (.*);

  assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

  logic [7:0] tb_vram [0:1023];
  always @(posedge clk) vram_rdata <= tb_vram[vram_raddr[9:0]];

  int checks = 0, fails = 0, lg_n = 0, cyc = 0, req_seen = 0;
  int lg_mem [0:63];
  logic [15:0] lg_addr [0:63];
  logic [15:0] lg_data [0:63];
  logic lg_byte [0:63];

  always @(negedge clk) begin
    if (bus_req) req_seen++;
    if (vram_we || cram_we || vsram_we) begin
      if (lg_n < 64) begin
        lg_mem[lg_n]  = vram_we ? 0 : cram_we ? 1 : 2;
        lg_addr[lg_n] = mem_addr;
        lg_data[lg_n] = mem_wdata;
        lg_byte[lg_n] = mem_byte;
      end
      lg_n++;
      if (vram_we) begin
        if (mem_byte) tb_vram[mem_addr[9:0]] = mem_wdata[7:0];
        else begin
          tb_vram[{mem_addr[9:1], 1'b0}] = mem_wdata[15:8];
          tb_vram[{mem_addr[9:1], 1'b1}] = mem_wdata[7:0];
        end
      end
    end
  end

  task automatic fin();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; $display("FAIL watchdog expired: actual=hung expected=done");
      fin();
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] typ, input logic [5:0] code, input logic [15:0] dest,
                       input logic [23:0] src, input logic [15:0] len, input logic [7:0] inc);
    logic [22:0] w;
    w = src[23:1];
    @(posedge clk); #1;
    cmd_code = code; cmd_dest = dest; len_lo = len[7:0]; len_hi = len[15:8]; auto_inc = inc;
    if (typ[1] == 1'b0) begin src_lo = w[7:0]; src_mid = w[15:8]; src_hi = {1'b0, w[22:16]}; end
    else begin src_lo = src[7:0]; src_mid = src[15:8]; src_hi = {typ, 6'd0}; end
    cmd_go = 1;
    @(posedge clk); #1;
    cmd_go = 0;
  endtask

  task automatic data_write(input logic [15:0] v);
    @(posedge clk); #1; data_wr = 1; data_word = v;
    @(posedge clk); #1; data_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 70000 && busy; i++) begin @(posedge clk); #1; end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  // typ, code, dest, src(byte), len, inc
  localparam int NV = 6;
  localparam logic [73:0] VEC [0:NV-1] = '{
    {2'b00, 6'h21, 16'h0100, 24'h002000, 16'd4, 8'd2},
    {2'b00, 6'h23, 16'h007C, 24'h010000, 16'd3, 8'd2},
    {2'b00, 6'h25, 16'h0010, 24'h7FFFFE, 16'd2, 8'd4},
    {2'b10, 6'h21, 16'h0200, 24'h000000, 16'd3, 8'd1},
    {2'b11, 6'h21, 16'h0300, 24'h000010, 16'd3, 8'd1},
    {2'b10, 6'h21, 16'hFFF0, 24'h000000, 16'd2, 8'h20}
  };

  initial begin
    for (int i = 0; i < 1024; i++) tb_vram[i] = pat(i);
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 writes", vram_we | cram_we | vsram_we, 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] typ; logic [5:0] code; logic [15:0] dest, len; logic [23:0] src; logic [7:0] inc;
      {typ, code, dest, src, len, inc} = VEC[v];
      lg_n = 0;
      start(typ, code, dest, src, len, inc);
      chk("R10 busy after start", busy, 1);
      if (typ == 2'b10) data_write(16'hAB12);
      wait_idle();
      chk("R10 busy end", busy, 0);
      chk("R10 bus_req end", bus_req, 0);
      chk("R3 R4 element count", lg_n, len);
      for (int k = 0; k < int'(len); k++) begin
        logic [15:0] ea, ed; int em; logic eb;
        ea = dest + 16'(k * inc);
        em = (typ[1] == 1'b1) ? 0 : (code[3:0] == 4'b0011) ? 1 : (code[3:0] == 4'b0101) ? 2 : 0;
        if (em != 0) ea = ea & 16'h007F;
        eb = typ[1];
        if (typ == 2'b10) ed = 16'h00AB;
        else if (typ == 2'b11) ed = {8'd0, pat(int'(src[9:0]) + k)};
        else ed = 16'(src + 24'(2 * k)) ^ 16'hA5C3;
        if (typ == 2'b00) begin
          chk("R5 R6 target", lg_mem[k], em);
          chk("R5 R6 data", lg_data[k], ed);
          chk("R6 R7 addr", lg_addr[k], ea);
          chk("R6 width", lg_byte[k], eb);
        end else if (typ == 2'b10) begin
          chk("R8 data", lg_data[k][7:0], ed[7:0]);
          chk("R7 R8 addr", lg_addr[k], ea);
          chk("R8 byte", {lg_mem[k][1:0], lg_byte[k]}, 3'b001);
        end else begin
          chk("R9 data", lg_data[k][7:0], ed[7:0]);
          chk("R7 R9 addr", lg_addr[k], ea);
          chk("R9 byte", {lg_mem[k][1:0], lg_byte[k]}, 3'b001);
        end
      end
    end

    // R2: DMA disabled, then DMA bit of code clear
    lg_n = 0; dma_en = 0;
    start(2'b00, 6'h21, 16'h0000, 24'h000100, 16'd2, 8'd2);
    repeat (3) @(posedge clk); #1;
    chk("R2 disabled busy", busy, 0);
    chk("R2 disabled writes", lg_n, 0);
    dma_en = 1;
    start(2'b00, 6'h01, 16'h0000, 24'h000100, 16'd2, 8'd2);
    repeat (3) @(posedge clk); #1;
    chk("R2 no dma bit busy", busy, 0);
    chk("R2 no dma bit writes", lg_n, 0);

    // R5: grant withheld
    lg_n = 0; bus_ack = 0;
    start(2'b00, 6'h21, 16'h0040, 24'h000400, 16'd2, 8'd2);
    repeat (5) @(posedge clk); #1;
    chk("R5 req held", bus_req, 1);
    chk("R5 no read", bus_rd, 0);
    chk("R5 no write", lg_n, 0);
    bus_ack = 1;
    wait_idle();
    chk("R5 after grant count", lg_n, 2);
    chk("R5 first word", lg_data[0], 16'h0400 ^ 16'hA5C3);

    // R8 + R11: fill waits; a start during the wait is ignored
    lg_n = 0; req_seen = 0;
    start(2'b10, 6'h21, 16'h0280, 24'h0, 16'd2, 8'd1);
    repeat (3) @(posedge clk); #1;
    chk("R8 waits for data", lg_n, 0);
    chk("R8 busy while waiting", busy, 1);
    start(2'b00, 6'h23, 16'h0000, 24'h000800, 16'd5, 8'd2);
    chk("R11 busy kept", busy, 1);
    data_write(16'h5A00);
    wait_idle();
    chk("R11 count", lg_n, 2);
    chk("R11 no bus request", req_seen, 0);
    chk("R11 fill value", lg_data[1][7:0], 8'h5A);
    chk("R11 target", {lg_mem[1][1:0], lg_byte[1]}, 3'b001);

    // R4: zero length means 65536
    lg_n = 0;
    start(2'b00, 6'h21, 16'h0000, 24'h000000, 16'd0, 8'd2);
    wait_idle();
    chk("R4 zero length count", lg_n, 65536);
    chk("R4 busy end", busy, 0);

    fin();
  end
endmodule